// File: doc/BRIEF.md
# Dual-Mode Packed Multiply-Accumulate Unit

This block is a multiply-accumulate datapath for fixed-point dot products. Each cycle it may take two 32-bit words, each packing two signed 16-bit lanes. Lane 0 sits in bits 15:0 and lane 1 in bits 31:16. The two lane pairs are multiplied at full 32-bit precision. A mode input picks where the products go. In pairwise-sum mode both products are added into accumulator 0. This fits a kernel of even width, which then needs half the steps. In split mode each product goes into its own accumulator. With the same weight in both lanes of operand B, that computes two neighbouring outputs of a stride-one convolution at once.

Each accumulator is 40 bits wide. A headroom enable picks the range used for the next update: the full 40 bits, or the signed 32-bit range when headroom is off. An update that would leave the active range clamps to the nearest limit. It also sets a sticky overflow flag for that accumulator. Two readout ports present each accumulator as a 16-bit value. The value is taken from a selectable bit position, rounded half-up, and saturated.

Top module: `vmac_unit`

## Requirements
- R1: After a synchronous reset both accumulators read 0, both overflow flags are 0 and both readouts are 0.
- R2: With `mode`=0 (pairwise sum) and `in_valid`=1, accumulator 0 gains A0*B0 + A1*B1, with signed lanes A0=`op_a[15:0]`, A1=`op_a[31:16]` and likewise for B. Accumulator 1 and its flag keep their values.
- R3: With `mode`=1 (split) and `in_valid`=1, accumulator 0 gains A0*B0 and accumulator 1 gains A1*B1 in the same update. The case B0=B1 is included.
- R4: An update shows at the outputs on the first clock edge after the cycle in which `in_valid` is sampled high. With `in_valid`=0 and `acc_clr`=0, the accumulators and flags keep their values whatever the operands, mode and headroom inputs are.
- R5: `acc_clr`=1 zeroes both accumulators and both flags on the next edge. This also happens when `in_valid` is high in the same cycle, and the operands are then discarded.
- R6: With `guard_en`=0, an update whose exact result lies outside [-2^31, 2^31-1] stores the nearest limit and sets that accumulator's flag.
- R7: With `guard_en`=1, results within [-2^39, 2^39-1] are stored exactly and leave the flag unchanged. Results beyond that range clamp to the nearest limit and set the flag.
- R8: An overflow flag, once set, stays at 1 until reset or `acc_clr`, whatever the later updates are.
- R9: For shift s = `rd_shift` in 0..39, each readout equals floor((acc + h) / 2^s), where h = 2^(s-1) for s>0 and h = 0 for s=0. This rounds half toward plus infinity.
- R10: A rounded readout value above 32767 reads as 32767, and one below -32768 reads as -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is valid this cycle |
| acc_clr | input | 1 | Clear both accumulators and flags (wins over in_valid) |
| mode | input | 1 | 0 = pairwise sum into acc 0, 1 = split into acc 0 / acc 1 |
| guard_en | input | 1 | 1 = 40-bit range, 0 = signed 32-bit range |
| op_a | input | 32 | Packed signed lanes A1:A0 |
| op_b | input | 32 | Packed signed lanes B1:B0 |
| rd_shift | input | 6 | Readout bit position (0..39) |
| acc0 | output | 40 | Accumulator 0, two's complement |
| acc1 | output | 40 | Accumulator 1, two's complement |
| ovf0 | output | 1 | Sticky overflow flag of accumulator 0 |
| ovf1 | output | 1 | Sticky overflow flag of accumulator 1 |
| rd0 | output | 16 | Rounded, saturated readout of accumulator 0 |
| rd1 | output | 16 | Rounded, saturated readout of accumulator 1 |

## Verification
Two pairs of functions can meet in one cycle. The first pair is clear and accumulate. The bench raises `acc_clr` together with a valid, non-zero operand pair, both after saturation and in a randomized stretch. It judges the result by all-zero accumulators and flags on the next edge, so no trace of the operands may remain. The second pair is a clamping update and the sticky flag. Once a flag is set, further updates in the opposite direction and across both modes must keep it high. The behavioural model is compared with every output on every clock.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

    parameter int LANE_W  = 16;
    parameter int ACC_W   = 32;
    parameter int GUARD_W = 8;
    parameter int LANES   = 2;

    localparam int EXT_W   = ACC_W + GUARD_W;
    localparam int PROD_W  = 2 * LANE_W;
    localparam int SUM_W   = EXT_W + 2;
    localparam int SHIFT_W = $clog2(EXT_W);
    localparam int WORD_W  = LANES * LANE_W;

    typedef enum logic {
        MODE_PAIRSUM = 1'b0,
        MODE_SPLIT   = 1'b1
    } vmac_mode_e;

    typedef struct packed {
        logic             en;
        logic [SUM_W-1:0] inc;
    } acc_cmd_t;

    typedef struct packed {
        logic             ovf;
        logic [EXT_W-1:0] val;
    } acc_state_t;

    function automatic logic [SUM_W-1:0] widen_prod(input logic [PROD_W-1:0] p);
        return {{(SUM_W-PROD_W){p[PROD_W-1]}}, p};
    endfunction

endpackage

// File: rtl/vmac_mul.sv
module vmac_mul #(
    parameter int LW = 16,
    localparam int PW = 2 * LW
) (
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    output logic [PW-1:0] p
);
    logic signed [PW-1:0] prod;

    always_comb begin
        prod = PW'($signed(a)) * PW'($signed(b));
        p    = prod;
    end
endmodule

// File: rtl/vmac_acc_lane.sv
module vmac_acc_lane #(
    parameter int AW = 32,
    parameter int GW = 8,
    localparam int EW = AW + GW,
    localparam int SW = EW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic          guard_en,
    input  logic [SW-1:0] inc,
    output logic [EW-1:0] val,
    output logic          ovf
);
    localparam logic signed [SW-1:0] ONE  = SW'(1);
    localparam logic signed [SW-1:0] HI_G = (ONE <<< (EW-1)) - ONE;
    localparam logic signed [SW-1:0] LO_G = -(ONE <<< (EW-1));
    localparam logic signed [SW-1:0] HI_N = (ONE <<< (AW-1)) - ONE;
    localparam logic signed [SW-1:0] LO_N = -(ONE <<< (AW-1));

    logic [EW-1:0]        val_q;
    logic                 ovf_q;
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] lim_hi;
    logic signed [SW-1:0] lim_lo;
    logic signed [SW-1:0] clamped;
    logic                 hit;

    always_comb begin
        sum    = $signed({{(SW-EW){val_q[EW-1]}}, val_q}) + $signed(inc);
        lim_hi = guard_en ? HI_G : HI_N;
        lim_lo = guard_en ? LO_G : LO_N;
        hit    = 1'b0;
        if (sum > lim_hi) begin
            clamped = lim_hi;
            hit     = 1'b1;
        end else if (sum < lim_lo) begin
            clamped = lim_lo;
            hit     = 1'b1;
        end else begin
            clamped = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            val_q <= '0;
            ovf_q <= 1'b0;
        end else if (en) begin
            val_q <= clamped[EW-1:0];
            ovf_q <= ovf_q | hit;
        end
    end

    assign val = val_q;
    assign ovf = ovf_q;
endmodule

// File: rtl/vmac_rdout.sv
module vmac_rdout #(
    parameter int EW = 40,
    parameter int OW = 16,
    localparam int HW = $clog2(EW),
    localparam int XW = EW + 1
) (
    input  logic [EW-1:0] acc,
    input  logic [HW-1:0] shift,
    output logic [OW-1:0] rd
);
    localparam logic signed [XW-1:0] ONE  = XW'(1);
    localparam logic signed [XW-1:0] O_HI = (ONE <<< (OW-1)) - ONE;
    localparam logic signed [XW-1:0] O_LO = -(ONE <<< (OW-1));

    logic signed [XW-1:0] ext;
    logic signed [XW-1:0] half;
    logic signed [XW-1:0] rounded;

    always_comb begin
        ext     = $signed({acc[EW-1], acc});
        half    = (shift == '0) ? '0 : (ONE << (shift - HW'(1)));
        rounded = (ext + half) >>> shift;
        if (rounded > O_HI)      rd = O_HI[OW-1:0];
        else if (rounded < O_LO) rd = O_LO[OW-1:0];
        else                     rd = rounded[OW-1:0];
    end
endmodule

// File: rtl/vmac_unit.sv
module vmac_unit
    import vmac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               acc_clr,
    input  logic               mode,
    input  logic               guard_en,
    input  logic [WORD_W-1:0]  op_a,
    input  logic [WORD_W-1:0]  op_b,
    input  logic [SHIFT_W-1:0] rd_shift,
    output logic [EXT_W-1:0]   acc0,
    output logic [EXT_W-1:0]   acc1,
    output logic               ovf0,
    output logic               ovf1,
    output logic [LANE_W-1:0]  rd0,
    output logic [LANE_W-1:0]  rd1
);
    vmac_mode_e              mode_e;
    logic [PROD_W-1:0]       prod [LANES];
    acc_cmd_t                cmd  [LANES];
    acc_state_t              st   [LANES];
    logic [LANE_W-1:0]       rdv  [LANES];

    assign mode_e = vmac_mode_e'(mode);

    for (genvar i = 0; i < LANES; i++) begin : g_mul
        vmac_mul #(.LW(LANE_W)) u_mul (
            .a (op_a[i*LANE_W +: LANE_W]),
            .b (op_b[i*LANE_W +: LANE_W]),
            .p (prod[i])
        );
    end

    always_comb begin
        cmd[0].en  = in_valid;
        cmd[0].inc = (mode_e == MODE_PAIRSUM)
                   ? widen_prod(prod[0]) + widen_prod(prod[1])
                   : widen_prod(prod[0]);
        cmd[1].en  = in_valid && (mode_e == MODE_SPLIT);
        cmd[1].inc = widen_prod(prod[1]);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_acc
        logic [EXT_W-1:0] v;
        logic             o;
        vmac_acc_lane #(.AW(ACC_W), .GW(GUARD_W)) u_acc (
            .clk      (clk),
            .rst      (rst),
            .clr      (acc_clr),
            .en       (cmd[i].en),
            .guard_en (guard_en),
            .inc      (cmd[i].inc),
            .val      (v),
            .ovf      (o)
        );
        assign st[i].val = v;
        assign st[i].ovf = o;

        vmac_rdout #(.EW(EXT_W), .OW(LANE_W)) u_rd (
            .acc   (v),
            .shift (rd_shift),
            .rd    (rdv[i])
        );
    end

    assign acc0 = st[0].val;
    assign acc1 = st[1].val;
    assign ovf0 = st[0].ovf;
    assign ovf1 = st[1].ovf;
    assign rd0  = rdv[0];
    assign rd1  = rdv[1];
endmodule

// File: rtl/vmac_unit_chk.sv
module vmac_unit_chk #(
    parameter int EW = 40,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          acc_clr,
    input logic          mode,
    input logic          guard_en,
    input logic [EW-1:0] acc0,
    input logic [EW-1:0] acc1,
    input logic          ovf0,
    input logic          ovf1
);
    localparam logic signed [EW-1:0] N_HI = (EW'(1) <<< (AW-1)) - EW'(1);
    localparam logic signed [EW-1:0] N_LO = -(EW'(1) <<< (AW-1));

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        acc_clr |=> (acc0 == '0) && (acc1 == '0) && !ovf0 && !ovf1); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !acc_clr) |=> $stable(acc0) && $stable(acc1)
                                     && $stable(ovf0) && $stable(ovf1)); // R4

    AST_PAIRSUM_ACC1_HOLD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !acc_clr && !mode) |=> $stable(acc1) && $stable(ovf1)); // R2

    AST_NOGUARD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !acc_clr && !guard_en)
            |=> ($signed(acc0) <= N_HI) && ($signed(acc0) >= N_LO)); // R6

    AST_OVF0_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf0 && !acc_clr) |=> ovf0); // R8

    AST_OVF1_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf1 && !acc_clr) |=> ovf1); // R8
endmodule

bind vmac_unit vmac_unit_chk #(
    .EW (vmac_pkg::EXT_W),
    .AW (vmac_pkg::ACC_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .acc_clr  (acc_clr),
    .mode     (mode),
    .guard_en (guard_en),
    .acc0     (acc0),
    .acc1     (acc1),
    .ovf0     (ovf0),
    .ovf1     (ovf1)
);

// File: tb/vmac_unit_tb.sv
module vmac_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        acc_clr = 1'b0;
    logic        mode = 1'b0;
    logic        guard_en = 1'b1;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [5:0]  rd_shift = '0;
    logic [39:0] acc0, acc1;
    logic        ovf0, ovf1;
    logic [15:0] rd0, rd1;

    always #10 clk = ~clk;

    vmac_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .acc_clr(acc_clr),
        .mode(mode), .guard_en(guard_en), .op_a(op_a), .op_b(op_b),
        .rd_shift(rd_shift), .acc0(acc0), .acc1(acc1), .ovf0(ovf0),
        .ovf1(ovf1), .rd0(rd0), .rd1(rd1)
    );

    longint m_acc [2];
    bit     m_ovf [2];
    string  tag = "R1";
    int     checks = 0;
    int     errors = 0;
    logic [31:0] seed = 32'h1234_5678;

    initial begin
        m_acc[0] = 0; m_acc[1] = 0; m_ovf[0] = 0; m_ovf[1] = 0;
    end

    task automatic m_apply(input int k, input longint inc, input bit g);
        longint s, hi, lo;
        s  = m_acc[k] + inc;
        hi = g ? ((64'sd1 <<< 39) - 1) : ((64'sd1 <<< 31) - 1);
        lo = -hi - 1;
        if (s > hi)      begin m_acc[k] = hi; m_ovf[k] = 1; end
        else if (s < lo) begin m_acc[k] = lo; m_ovf[k] = 1; end
        else             m_acc[k] = s;
    endtask

    // Behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        longint p0, p1;
        p0 = longint'(shortint'(op_a[15:0]))  * longint'(shortint'(op_b[15:0]));
        p1 = longint'(shortint'(op_a[31:16])) * longint'(shortint'(op_b[31:16]));
        if (rst || acc_clr) begin
            m_acc[0] = 0; m_acc[1] = 0; m_ovf[0] = 0; m_ovf[1] = 0;
        end else if (in_valid) begin
            if (!mode) m_apply(0, p0 + p1, guard_en);
            else begin
                m_apply(0, p0, guard_en);
                m_apply(1, p1, guard_en);
            end
        end
    end

    function automatic longint exp_rd(input longint v, input int s);
        longint t;
        t = (s == 0) ? v : ((v + (64'sd1 <<< (s - 1))) >>> s);
        return t;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        longint r;
        longint rs;
        chk(tag, "acc0", longint'($signed(acc0)), m_acc[0]);
        chk(tag, "acc1", longint'($signed(acc1)), m_acc[1]);
        chk((tag == "R8") ? "R8" : tag, "ovf", longint'({ovf1, ovf0}),
            longint'({m_ovf[1], m_ovf[0]}));
        for (int k = 0; k < 2; k++) begin
            r  = exp_rd(m_acc[k], int'(rd_shift));
            rs = (r > 32767) ? 32767 : ((r < -32768) ? -32768 : r);
            chk((rs != r) ? "R10" : "R9", (k == 0) ? "rd0" : "rd1",
                longint'($signed((k == 0) ? rd0 : rd1)), rs);
        end
    endtask

    function automatic logic [31:0] pk(input int hi, input int lo);
        return {hi[15:0], lo[15:0]};
    endfunction

    task automatic cyc(input bit v, input bit c, input bit m, input bit g,
                       input logic [31:0] a, input logic [31:0] b, input int s);
        @(negedge clk);
        check_all();
        in_valid = v; acc_clr = c; mode = m; guard_en = g;
        op_a = a; op_b = b; rd_shift = 6'(s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all();               // R1 during reset
        rst = 1'b0;
        tag = "R1";
        cyc(0, 0, 0, 1, '0, '0, 0);
        cyc(0, 0, 0, 1, '0, '0, 3);

        tag = "R2";
        cyc(1, 0, 0, 1, pk(3, 2), pk(-4, 5), 0);
        cyc(1, 0, 0, 1, pk(-32768, -32768), pk(-32768, -32768), 0);
        cyc(1, 0, 0, 1, pk(-7, 100), pk(9, -3), 16);
        cyc(1, 0, 0, 1, pk(32767, -1), pk(-32768, 1), 20);
        cyc(0, 0, 0, 1, '0, '0, 31);

        tag = "R5";
        cyc(0, 1, 0, 1, '0, '0, 0);
        tag = "R3";
        cyc(1, 0, 1, 1, pk(11, -6), pk(-2, 3), 0);
        cyc(1, 0, 1, 1, pk(1234, -321), pk(77, 77), 2);
        cyc(1, 0, 1, 1, pk(-500, 250), pk(-9, -9), 1);
        cyc(1, 0, 1, 1, pk(1, 5), pk(1, 1), 3);

        tag = "R4";
        cyc(0, 0, 0, 0, 32'hDEAD_BEEF, 32'h8001_7FFF, 4);
        cyc(0, 0, 1, 1, 32'h7FFF_8000, 32'h7FFF_8000, 5);
        cyc(0, 0, 0, 0, 32'h1111_2222, 32'h3333_4444, 0);
        cyc(1, 0, 1, 1, pk(2, 3), pk(4, 5), 0);
        cyc(0, 0, 1, 0, '0, '0, 0);

        tag = "R5";
        cyc(1, 1, 1, 1, pk(300, 400), pk(500, 600), 0);
        cyc(1, 1, 0, 1, pk(-300, 400), pk(500, -600), 0);

        tag = "R6";
        cyc(0, 1, 0, 0, '0, '0, 0);
        for (int i = 0; i < 3; i++)
            cyc(1, 0, 0, 0, pk(-32768, -32768), pk(-32768, -32768), 16);
        for (int i = 0; i < 3; i++)
            cyc(1, 0, 1, 0, pk(-32768, -32768), pk(32767, 32767), 24);

        tag = "R8";
        for (int i = 0; i < 4; i++)
            cyc(1, 0, i[0], 0, pk(-32768, 100), pk(-32768, 7), 8);
        cyc(0, 0, 0, 1, '0, '0, 0);

        tag = "R5";
        cyc(1, 1, 0, 1, pk(9, 9), pk(9, 9), 0);
        tag = "R7";
        cyc(0, 0, 0, 1, '0, '0, 0);
        for (int i = 0; i < 262; i++)
            cyc(1, 0, 0, 1, pk(-32768, -32768), pk(-32768, -32768), i % 40);
        for (int i = 0; i < 4; i++)
            cyc(1, 0, 1, 1, pk(-32768, 32767), pk(32767, 32767), 39 - i);

        tag = "R9";
        cyc(0, 1, 0, 1, '0, '0, 0);
        cyc(1, 0, 1, 1, pk(5, 6), pk(1, 1), 0);
        cyc(0, 0, 0, 1, '0, '0, 1);
        cyc(0, 0, 0, 1, '0, '0, 2);
        cyc(1, 0, 1, 1, pk(-11, -12), pk(1, 1), 2);
        cyc(0, 0, 0, 1, '0, '0, 1);
        cyc(0, 0, 0, 1, '0, '0, 3);

        tag = "R4";
        for (int i = 0; i < 3000; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            cyc(seed[0] | seed[1], seed[9:2] == 8'h00, seed[10], seed[13:11] != 3'd0,
                {seed[31:16], seed[15:0] ^ 16'h5A5A},
                {seed[15:0], seed[31:16]}, int'(seed[20:16]) + int'(seed[22:21]));
        end

        @(negedge clk);
        check_all();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule